// File: doc/BRIEF.md
# Switched-Capacitor Converter Switch Phase Controller

This block drives the gates of the four power switches, here called A, B, C and D, of a step-down switched-capacitor converter. Its inputs are a switching clock, two output-enable lines, a ratio request and a comparator flag that is high while the converter output sits at or above its regulation point. In half ratio it runs a two-phase cycle. A and C conduct in the first phase, then B and D conduct in the second, and an all-off gap separates each phase from the next. In unity ratio C and D stay off, and A and B open and close together.

The controller idles with every switch off while the output is in regulation. It starts switching again only after the synchronized flag shows the output has dropped. It is also held off while both enables are low. Phase length and dead-gap length come from plain configuration inputs. All pins are plain control and status signals; no data stream crosses the boundary, so no valid/ready handshake is used.

Top module: `cpsw_phase_ctrl`

## Requirements
- R1: During and after reset, with no enable high, all four switch outputs are low, `sleeping` is 1 and `mode_1to1` is 0.
- R2: In half ratio (`mode_1to1`=0) the drive phase with A and C on (pattern {a,b,c,d}=1010) lasts max(`phase_cfg`,1) cycles. It is followed by a dead gap and then by a phase of the same length with B and D on (0101).
- R3: In unity ratio (`mode_1to1`=1) C and D never turn on. A and B are on together (1100) for one phase, then all four are off for the second phase.
- R4: Between any two drive phases all switches are off for max(`dead_cfg`,1) cycles. Two different non-zero patterns never appear on consecutive cycles, and C is never on together with B or D.
- R5: Once the synchronized regulation flag is high, the next clock edge puts the block in sleep: all switches are off and `sleeping`=1, whatever phase was running.
- R6: Sleep persists while the synchronized flag stays high, even with an enable high. Leaving sleep always begins with the first drive phase.
- R7: When both `en_a` and `en_b` are low, the next edge forces sleep with all switches off. Either enable alone is enough to run. The enables are not synchronized.
- R8: A change of `mode_req` (1 requests unity ratio) is applied only when a first drive phase begins. `mode_1to1` changes only on that edge, and a phase already under way finishes in the old ratio.
- R9: `in_reg` passes through two flip-flops. A change of `in_reg` before edge k first affects the switch outputs after edge k+2.
- R10: A configuration value of 0 for `phase_cfg` or `dead_cfg` is treated as one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | switching clock |
| rst_n | input | 1 | active-low asynchronous reset |
| en_a | input | 1 | enable of the first output rail |
| en_b | input | 1 | enable of the second output rail |
| mode_req | input | 1 | 1 requests unity ratio, 0 half ratio |
| in_reg | input | 1 | asynchronous flag, 1 when output is at or above regulation |
| phase_cfg | input | PHASE_W | drive-phase length in cycles (0 means 1) |
| dead_cfg | input | DEAD_W | dead-gap length in cycles (0 means 1) |
| sw_a | output | 1 | gate enable of switch A |
| sw_b | output | 1 | gate enable of switch B |
| sw_c | output | 1 | gate enable of switch C |
| sw_d | output | 1 | gate enable of switch D |
| mode_1to1 | output | 1 | active ratio, 1 for unity |
| sleeping | output | 1 | 1 while in sleep |

## Verification
The bench requests a ratio change in the middle of a half-ratio cycle. A design that applies the request at once would cut a B/D phase short or show the unity pattern too early. It raises the regulation flag while A and C are conducting and expects exactly two further conducting cycles. A missing or extra synchronizer stage shifts the sleep entry by a cycle and is caught. It also drops both enables mid-phase, wakes on one enable alone, and sets the zero configuration values. A design that counted zero as a full wrap, or that skipped the dead gap, would produce a wrong pattern stream against the scoreboard.

// File: rtl/cpsw_pkg.sv
package cpsw_pkg;
  typedef enum logic [2:0] {
    ST_SLEEP  = 3'd0,
    ST_DRIVE1 = 3'd1,
    ST_GAP1   = 3'd2,
    ST_DRIVE2 = 3'd3,
    ST_GAP2   = 3'd4
  } phase_e;

  typedef enum logic {
    RATIO_HALF  = 1'b0,
    RATIO_UNITY = 1'b1
  } ratio_e;

  typedef struct packed {
    logic a;
    logic b;
    logic c;
    logic d;
  } gates_t;
endpackage

// File: rtl/cpsw_sync2.sv
module cpsw_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/cpsw_seq.sv
module cpsw_seq
  import cpsw_pkg::*;
#(
  parameter int PHASE_W = 8,
  parameter int DEAD_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               reg_ok,
  input  logic               mode_req,
  input  logic [PHASE_W-1:0] phase_cfg,
  input  logic [DEAD_W-1:0]  dead_cfg,
  output phase_e             state,
  output ratio_e             ratio
);
  localparam int CW = (PHASE_W > DEAD_W) ? PHASE_W : DEAD_W;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] phase_len, dead_len, phase_last, dead_last;
  phase_e        state_d;
  logic          latch_ratio;
  logic          phase_done, gap_done;

  assign phase_len  = (phase_cfg == '0) ? CW'(1) : CW'(phase_cfg);
  assign dead_len   = (dead_cfg  == '0) ? CW'(1) : CW'(dead_cfg);
  assign phase_last = phase_len - CW'(1);
  assign dead_last  = dead_len - CW'(1);
  assign phase_done = (cnt_q >= phase_last);
  assign gap_done   = (cnt_q >= dead_last);

  always_comb begin
    state_d     = state;
    cnt_d       = cnt_q + CW'(1);
    latch_ratio = 1'b0;
    if (!run || reg_ok) begin
      state_d = ST_SLEEP;
      cnt_d   = '0;
    end else begin
      unique case (state)
        ST_SLEEP: begin
          state_d     = ST_DRIVE1;
          cnt_d       = '0;
          latch_ratio = 1'b1;
        end
        ST_DRIVE1: if (phase_done) begin
          state_d = ST_GAP1;
          cnt_d   = '0;
        end
        ST_GAP1: if (gap_done) begin
          state_d = ST_DRIVE2;
          cnt_d   = '0;
        end
        ST_DRIVE2: if (phase_done) begin
          state_d = ST_GAP2;
          cnt_d   = '0;
        end
        ST_GAP2: if (gap_done) begin
          state_d     = ST_DRIVE1;
          cnt_d       = '0;
          latch_ratio = 1'b1;
        end
        default: begin
          state_d = ST_SLEEP;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_SLEEP;
      cnt_q <= '0;
      ratio <= RATIO_HALF;
    end else begin
      state <= state_d;
      cnt_q <= cnt_d;
      if (latch_ratio) ratio <= mode_req ? RATIO_UNITY : RATIO_HALF;
    end
  end

  // R5
  sleep_on_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_ok |=> (state == ST_SLEEP));

  // R6
  wake_first_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP) |=> (state == ST_SLEEP || state == ST_DRIVE1));

  // R8
  ratio_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio != $past(ratio)) |-> (state == ST_DRIVE1 && cnt_q == '0));
endmodule

// File: rtl/cpsw_gate_decode.sv
module cpsw_gate_decode
  import cpsw_pkg::*;
(
  input  phase_e state,
  input  ratio_e ratio,
  output gates_t gates
);
  always_comb begin
    gates = '0;
    unique case (state)
      ST_DRIVE1: begin
        gates.a = 1'b1;
        if (ratio == RATIO_UNITY) gates.b = 1'b1;
        else                      gates.c = 1'b1;
      end
      ST_DRIVE2: begin
        if (ratio == RATIO_HALF) begin
          gates.b = 1'b1;
          gates.d = 1'b1;
        end
      end
      default: gates = '0;
    endcase
  end
endmodule

// File: rtl/cpsw_phase_ctrl.sv
module cpsw_phase_ctrl
  import cpsw_pkg::*;
#(
  parameter int PHASE_W = 8,
  parameter int DEAD_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_a,
  input  logic               en_b,
  input  logic               mode_req,
  input  logic               in_reg,
  input  logic [PHASE_W-1:0] phase_cfg,
  input  logic [DEAD_W-1:0]  dead_cfg,
  output logic               sw_a,
  output logic               sw_b,
  output logic               sw_c,
  output logic               sw_d,
  output logic               mode_1to1,
  output logic               sleeping
);
  logic   reg_ok;
  phase_e state;
  ratio_e ratio;
  gates_t gates;
  logic   run;

  assign run = en_a | en_b;

  cpsw_sync2 #(.RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (in_reg),
    .q     (reg_ok)
  );

  cpsw_seq #(.PHASE_W(PHASE_W), .DEAD_W(DEAD_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .reg_ok    (reg_ok),
    .mode_req  (mode_req),
    .phase_cfg (phase_cfg),
    .dead_cfg  (dead_cfg),
    .state     (state),
    .ratio     (ratio)
  );

  cpsw_gate_decode u_dec (
    .state (state),
    .ratio (ratio),
    .gates (gates)
  );

  assign sw_a      = gates.a;
  assign sw_b      = gates.b;
  assign sw_c      = gates.c;
  assign sw_d      = gates.d;
  assign mode_1to1 = (ratio == RATIO_UNITY);
  assign sleeping  = (state == ST_SLEEP);

  // R4
  c_partner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_c |-> (sw_a && !sw_b && !sw_d));

  // R4
  d_partner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_d |-> (sw_b && !sw_a && !sw_c));

  // R4
  gap_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|$past({sw_a, sw_b, sw_c, sw_d})) && (|{sw_a, sw_b, sw_c, sw_d}))
      |-> ({sw_a, sw_b, sw_c, sw_d} == $past({sw_a, sw_b, sw_c, sw_d})));

  // R3
  unity_cd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_1to1 |-> (!sw_c && !sw_d));

  // R7
  disabled_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_a && !en_b) |=> (sleeping && !sw_a && !sw_b && !sw_c && !sw_d));
endmodule

// File: tb/cpsw_phase_ctrl_test.sv
`timescale 1ns/1ps
module cpsw_phase_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n, en_a, en_b, mode_req, in_reg;
  logic [7:0] phase_cfg;
  logic [3:0] dead_cfg;
  logic       sw_a, sw_b, sw_c, sw_d, mode_1to1, sleeping;

  typedef struct {
    logic [3:0] sw;
    logic       slp;
    logic       m;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   fails = 0;
  bit   done  = 0;

  localparam logic [3:0] OFF = 4'b0000;
  localparam logic [3:0] AC  = 4'b1010;
  localparam logic [3:0] BD  = 4'b0101;
  localparam logic [3:0] AB  = 4'b1100;

  always #2.5 clk = ~clk;

  cpsw_phase_ctrl uut (
    .clk(clk), .rst_n(rst_n), .en_a(en_a), .en_b(en_b), .mode_req(mode_req),
    .in_reg(in_reg), .phase_cfg(phase_cfg), .dead_cfg(dead_cfg),
    .sw_a(sw_a), .sw_b(sw_b), .sw_c(sw_c), .sw_d(sw_d),
    .mode_1to1(mode_1to1), .sleeping(sleeping)
  );

  task automatic compare(input logic [3:0] sw, input logic slp, input logic m, input string tag);
    total++;
    if ({sw_a, sw_b, sw_c, sw_d} !== sw || sleeping !== slp || mode_1to1 !== m) begin
      fails++;
      $display("FAIL %s: got sw=%b slp=%b mode=%b, expected sw=%b slp=%b mode=%b",
               tag, {sw_a, sw_b, sw_c, sw_d}, sleeping, mode_1to1, sw, slp, m);
    end
  endtask

  task automatic push(input logic [3:0] sw, input logic slp, input logic m, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.sw = sw; e.slp = slp; e.m = m; e.tag = tag;
      q.push_back(e);
    end
  endtask

  task automatic drain();
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  // monitor: one expected item per rising edge, sampled 1 ns later
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        compare(e.sw, e.slp, e.m, e.tag);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: got no end, expected end of test");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en_a = 1'b0; en_b = 1'b0; mode_req = 1'b0; in_reg = 1'b1;
    phase_cfg = 8'd3; dead_cfg = 4'd2;
    repeat (3) @(negedge clk);
    compare(OFF, 1'b1, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    push(OFF, 1'b1, 1'b0, 3, "R1 after reset, no enable");
    drain();

    en_a = 1'b1;
    push(OFF, 1'b1, 1'b0, 4, "R6 enabled but regulated stays asleep");
    drain();

    in_reg = 1'b0;
    push(OFF, 1'b1, 1'b0, 2, "R9 synchronizer delay on wake");
    push(AC,  1'b0, 1'b0, 3, "R2 first phase A+C");
    push(OFF, 1'b0, 1'b0, 2, "R4 dead gap");
    push(BD,  1'b0, 1'b0, 3, "R2 second phase B+D");
    push(OFF, 1'b0, 1'b0, 2, "R4 dead gap");
    push(AC,  1'b0, 1'b0, 3, "R2 first phase again");
    drain();

    mode_req = 1'b1;
    push(OFF, 1'b0, 1'b0, 2, "R8 gap keeps old ratio");
    push(BD,  1'b0, 1'b0, 3, "R8 running cycle finishes in half ratio");
    push(OFF, 1'b0, 1'b0, 2, "R8 gap keeps old ratio");
    push(AB,  1'b0, 1'b1, 3, "R3 unity A+B together");
    push(OFF, 1'b0, 1'b1, 2, "R3 unity gap");
    push(OFF, 1'b0, 1'b1, 3, "R3 unity second phase all off");
    push(OFF, 1'b0, 1'b1, 2, "R3 unity gap");
    push(AB,  1'b0, 1'b1, 3, "R3 unity A+B again");
    drain();

    mode_req = 1'b0;
    push(OFF, 1'b0, 1'b1, 2, "R8 unity held to boundary");
    push(OFF, 1'b0, 1'b1, 3, "R8 unity held to boundary");
    push(OFF, 1'b0, 1'b1, 2, "R8 unity held to boundary");
    push(AC,  1'b0, 1'b0, 1, "R8 half ratio at phase start");
    drain();

    in_reg = 1'b1;
    push(AC,  1'b0, 1'b0, 2, "R9 two cycles before flag acts");
    push(OFF, 1'b1, 1'b0, 4, "R5 sleep in regulation");
    drain();

    in_reg = 1'b0;
    push(OFF, 1'b1, 1'b0, 2, "R6 asleep until flag synchronized");
    push(AC,  1'b0, 1'b0, 3, "R6 wake into first phase");
    push(OFF, 1'b0, 1'b0, 2, "R4 dead gap");
    push(BD,  1'b0, 1'b0, 1, "R2 second phase");
    drain();

    en_a = 1'b0;
    push(OFF, 1'b1, 1'b0, 3, "R7 both enables low forces sleep");
    drain();

    en_b = 1'b1; phase_cfg = 8'd0; dead_cfg = 4'd0;
    push(AC,  1'b0, 1'b0, 1, "R10 zero phase is one cycle, R7 en_b alone runs");
    push(OFF, 1'b0, 1'b0, 1, "R10 zero gap is one cycle");
    push(BD,  1'b0, 1'b0, 1, "R10 zero phase is one cycle");
    push(OFF, 1'b0, 1'b0, 1, "R10 zero gap is one cycle");
    push(AC,  1'b0, 1'b0, 1, "R10 cycle repeats");
    drain();

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule